// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one timer channel built around a 32-bit down-counter. When the channel is enabled it loads a stored reload value and then steps down by one on every selected tick. The tick is either every cycle of the system clock or the rising edge of a slow external tick input, which is synchronised into the clock domain first. After the count reaches zero it starts again from the reload value. A reload value of zero leaves the counter parked at zero.

Two match registers, written in either order, are compared against each new count value. A third comparison sits at zero. Every qualifying event inverts a level-type interrupt output; no pulse is produced. Software-side logic, not part of this block, writes the count, reload and match registers through one-cycle write strobes that share a data bus. The enable, clock-source and zero-interrupt controls are plain level inputs. Every port is a plain control or status pin, so the block has no flow-controlled stream interface and applies no back-pressure.

Top module: `tmr_channel`

## Requirements
- R1: Reset clears the count, the reload value, both match values and the interrupt level to zero. After reset, enabling the channel with no reload write leaves the count at zero.
- R2: A rising edge on `enable` loads the stored reload value into the count. While enabled with `ext_sel`=0, the count then falls by exactly one on every clock edge.
- R3: While enabled, a tick at a count of zero loads the reload value. The load at zero raises no event.
- R4: With a reload value of zero, the count stays at zero and the interrupt level does not change.
- R5: A decrement whose new count equals a nonzero match value is an event. The two match registers act the same whichever holds the larger value, so the larger match fires before the smaller. If both registers hold the same value, only one event occurs.
- R6: A decrement that reaches zero is an event when `ovf_irq_en`=1 or when either match register holds zero. Otherwise, reaching zero is not an event.
- R7: Each event inverts `irq_level` on the same clock edge as the decrement that caused it. At all other times the level holds.
- R8: With `ext_sel`=1, the count falls by one for each rising edge of `ext_tick`, however long the input stays high. If `ext_tick` is first sampled high at clock edge k, the decrement happens at edge k+2.
- R9: A `wr_count` strobe while enabled loads `wr_data` into the count on that edge. While disabled, the strobe leaves the count unchanged.
- R10: A `wr_reload` strobe always stores `wr_data`. The count is also loaded with `wr_data` only when the channel is enabled, the old reload is zero and `wr_data` is nonzero. In every other case the count is unaffected.
- R11: While `enable`=0, the count and `irq_level` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each cycle is one tick when `ext_sel`=0 |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run control; a rising edge restarts from the reload value |
| ext_sel | input | 1 | Tick source: 0 = system clock, 1 = external tick |
| ovf_irq_en | input | 1 | Allows an event when the count reaches zero |
| ext_tick | input | 1 | Asynchronous external tick, one decrement per rising edge |
| wr_count | input | 1 | Write strobe for the live count |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_match_a | input | 1 | Write strobe for match register A |
| wr_match_b | input | 1 | Write strobe for match register B |
| wr_data | input | 32 | Data for whichever write strobe is active |
| count | output | 32 | Live count value |
| irq_level | output | 1 | Interrupt level, inverted on each event |

## Verification
The bench aims at the places where the counter's ordering rules are easy to get wrong. Match values are loaded smaller-first and then set equal. A design that assumes the registers are sorted would skip one event, and a design that ORs the comparisons badly would toggle twice on equal matches and so leave the level unchanged. The zero boundary is run with the zero-interrupt enable off, with it on, and with a zero match value. A design that always toggles at zero, or never does, shows up as a level of the wrong phase. The bench also writes a zero reload followed by a nonzero one, and writes the count while the channel is disabled. A design that restarts on every reload write, or that accepts count writes while stopped, gives a count that departs from the expected sequence. External ticks are held high for several cycles, which catches a design that counts levels instead of edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W       = 32;
  localparam int unsigned N_MATCH     = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    SRC_SYSCLK  = 1'b0,
    SRC_EXTTICK = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic ext_raw,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              edge_pulse;
  tick_src_e         src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_raw};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_pulse = sync_q[STAGES-1] & ~last_q;
  assign src        = tick_src_e'(src_sel);
  assign tick_o     = (src == SRC_EXTTICK) ? edge_pulse : 1'b1;

  // R8: an external edge yields a tick lasting one cycle only
  p_single_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/tmr_match_eval.sv
module tmr_match_eval
  import tmr_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned NM = N_MATCH
) (
  input  logic [W-1:0]         nxt_i,
  input  logic [NM-1:0][W-1:0] match_i,
  input  logic                 ovf_en_i,
  output logic                 hit_o
);
  logic [NM-1:0] eq_hit;
  logic [NM-1:0] zero_set;

  for (genvar g = 0; g < NM; g++) begin : g_cmp
    assign zero_set[g] = (match_i[g] == '0);
    assign eq_hit[g]   = !zero_set[g] && (nxt_i == match_i[g]);
  end

  assign hit_o = (|eq_hit) || ((nxt_i == '0) && (ovf_en_i || (|zero_set)));
endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         wr_count_i,
  input  logic         wr_reload_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         dec_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic         en_q;
  logic         start_en;
  logic         load_wr;
  logic         start_rl;
  logic         any_load;

  assign start_en = en_i && !en_q;
  assign load_wr  = en_i && wr_count_i;
  assign start_rl = en_i && wr_reload_i && (reload_q == '0) && (wr_data_i != '0);
  assign any_load = start_en || load_wr || start_rl;
  assign nxt_o    = cnt_q - W'(1);
  assign dec_o    = en_i && !any_load && tick_i && (cnt_q != '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      en_q     <= 1'b0;
    end else begin
      en_q <= en_i;
      if (wr_reload_i) reload_q <= wr_data_i;
      if (start_en)                     cnt_q <= reload_q;
      else if (load_wr)                 cnt_q <= wr_data_i;
      else if (start_rl)                cnt_q <= wr_data_i;
      else if (en_i && tick_i) begin
        if (cnt_q == '0)                cnt_q <= reload_q;
        else                            cnt_q <= nxt_o;
      end
    end
  end

  // R2: enable edge restarts from the stored reload value
  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !en_q) |=> (cnt_q == $past(reload_q)));
  // R2: an unobstructed tick lowers the count by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R3: a tick at zero reloads
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !any_load && tick_i && cnt_q == '0) |=> (cnt_q == $past(reload_q)));
  // R9: count write while running takes the bus value
  p_count_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && en_q && wr_count_i) |=> (cnt_q == $past(wr_data_i)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W      = CNT_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         ext_sel,
  input  logic         ovf_irq_en,
  input  logic         ext_tick,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic         wr_match_a,
  input  logic         wr_match_b,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         irq_level
);
  localparam int unsigned NM = N_MATCH;

  logic                 tick;
  logic [W-1:0]         nxt;
  logic                 dec;
  logic                 hit;
  logic                 evt;
  logic [NM-1:0][W-1:0] match_q;
  logic [NM-1:0]        match_wr;
  logic                 irq_q;

  assign match_wr = {wr_match_b, wr_match_a};

  tmr_tick_sel #(.STAGES(STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_sel(ext_sel), .ext_raw(ext_tick), .tick_o(tick)
  );

  tmr_downcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .tick_i(tick),
    .wr_count_i(wr_count), .wr_reload_i(wr_reload), .wr_data_i(wr_data),
    .cnt_o(count), .nxt_o(nxt), .dec_o(dec)
  );

  tmr_match_eval #(.W(W), .NM(NM)) u_cmp (
    .nxt_i(nxt), .match_i(match_q), .ovf_en_i(ovf_irq_en), .hit_o(hit)
  );

  for (genvar g = 0; g < NM; g++) begin : g_mreg
    always_ff @(posedge clk) begin
      if (!rst_n)           match_q[g] <= '0;
      else if (match_wr[g]) match_q[g] <= wr_data;
    end
  end

  assign evt = dec && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_q ^ evt;
  end

  assign irq_level = irq_q;

  // R7: level moves only on an event
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(irq_q));
  // R11: a stopped channel freezes count and level
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(count) && $stable(irq_q)));
  // R4: zero reload keeps a running channel at zero
  p_zero_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && count == '0 && !wr_count && !wr_reload
     && $past(!wr_reload) && $past(!wr_count)) |=> ($stable(irq_q)));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb_top;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] cnt;
    logic         irq;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0, ext_sel = 1'b0, ovf_irq_en = 1'b0, ext_tick = 1'b0;
  logic         wr_count = 1'b0, wr_reload = 1'b0, wr_match_a = 1'b0, wr_match_b = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic         irq_level;

  int    vectors = 0;
  int    fails   = 0;
  string cur_req = "R1";
  exp_t  q[$];

  always #2.5 clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
    .ovf_irq_en(ovf_irq_en), .ext_tick(ext_tick), .wr_count(wr_count),
    .wr_reload(wr_reload), .wr_match_a(wr_match_a), .wr_match_b(wr_match_b),
    .wr_data(wr_data), .count(count), .irq_level(irq_level)
  );

  // Reference model built from R1..R11; pushes one expectation per edge
  logic [W-1:0] m_cnt, m_rl, m_ma, m_mb;
  logic         m_irq, m_enq, m_s1, m_s2, m_p;
  always @(posedge clk) begin
    exp_t e;
    logic tk, ld;
    logic [W-1:0] nx;
    if (!rst_n) begin
      m_cnt = '0; m_rl = '0; m_ma = '0; m_mb = '0;
      m_irq = 0; m_enq = 0; m_s1 = 0; m_s2 = 0; m_p = 0;
    end else begin
      tk = ext_sel ? (m_s2 && !m_p) : 1'b1;   // R8 latency of two edges
      ld = 1'b1;
      if (enable && !m_enq)                     m_cnt = m_rl;
      else if (enable && wr_count)              m_cnt = wr_data;
      else if (enable && wr_reload && m_rl == 0 && wr_data != 0) m_cnt = wr_data;
      else ld = 1'b0;
      if (!ld && enable && tk) begin
        if (m_cnt == 0) m_cnt = m_rl;
        else begin
          nx = m_cnt - 1;
          if ((nx == m_ma && m_ma != 0) || (nx == m_mb && m_mb != 0) ||
              (nx == 0 && (ovf_irq_en || m_ma == 0 || m_mb == 0)))
            m_irq = !m_irq;
          m_cnt = nx;
        end
      end
      if (wr_reload)  m_rl = wr_data;
      if (wr_match_a) m_ma = wr_data;
      if (wr_match_b) m_mb = wr_data;
      m_enq = enable;
      m_p = m_s2; m_s2 = m_s1; m_s1 = ext_tick;
      e.cnt = m_cnt; e.irq = m_irq; e.req = cur_req;
      q.push_back(e);
    end
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (count !== e.cnt || irq_level !== e.irq) begin
        fails++;
        $display("FAIL %s: actual count=%0d irq=%0b expected count=%0d irq=%0b",
                 e.req, count, irq_level, e.cnt, e.irq);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int which, input logic [W-1:0] d);
    @(negedge clk);
    wr_data = d;
    case (which)
      0: wr_count   = 1'b1;
      1: wr_reload  = 1'b1;
      2: wr_match_a = 1'b1;
      default: wr_match_b = 1'b1;
    endcase
    @(negedge clk);
    wr_count = 0; wr_reload = 0; wr_match_a = 0; wr_match_b = 0;
  endtask

  task automatic direct_check(input string req, input logic [W-1:0] ec, input logic ei);
    vectors++;
    if (count !== ec || irq_level !== ei) begin
      fails++;
      $display("FAIL %s: actual count=%0d irq=%0b expected count=%0d irq=%0b",
               req, count, irq_level, ec, ei);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=run complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cyc(4);
    direct_check("R1", '0, 1'b0);          // R1 reset state
    rst_n = 1'b1;
    cur_req = "R1 R4"; enable = 1'b1; cyc(6);   // reload cleared, parks at 0
    enable = 1'b0; cyc(2);
    cur_req = "R2 R5";
    wr(3, 5); wr(2, 15); wr(1, 20);        // smaller match written first
    enable = 1'b1; cyc(30);                // R2 step, R5 order, R3 wrap
    cur_req = "R3 R6"; cyc(20);            // zero reached with no zero event
    cur_req = "R6"; ovf_irq_en = 1'b1; cyc(22);
    ovf_irq_en = 1'b0; wr(2, 0); cyc(22);  // zero match forces zero event
    cur_req = "R5 R7"; wr(2, 8); wr(3, 8); cyc(25);  // equal matches: one toggle
    cur_req = "R9"; wr(0, 100); cyc(5);
    cur_req = "R11"; enable = 1'b0; cyc(8);
    cur_req = "R9 R11"; wr(0, 3); cyc(4);  // ignored while stopped
    cur_req = "R10"; enable = 1'b1; cyc(3);
    wr(1, 0); cyc(25);                     // stored only, reaches 0 and parks
    cur_req = "R4"; cyc(8);
    cur_req = "R10"; wr(1, 12); cyc(4);    // zero->nonzero restart
    wr(1, 30); cyc(20);                    // stored only, used at wrap
    cur_req = "R8"; ext_sel = 1'b1;
    for (int i = 0; i < 12; i++) begin
      ext_tick = 1'b1; cyc(3);
      ext_tick = 1'b0; cyc(4);
    end
    cyc(4);
    cur_req = "R1"; rst_n = 1'b0; cyc(2);
    direct_check("R1", '0, 1'b0);
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule